// File: doc/BRIEF.md
# Configuration Space Target

This block is the configuration-cycle responder of one bus agent on a parallel, multiplexed address/data bus with active-low handshakes. It holds a 256-byte configuration space: a 64-byte standard header with identity, control and base-address fields, followed by a user region. It claims a cycle only when its dedicated chip-select input is high during the address phase. The address itself is never compared, so the host can configure the agent before any address is assigned.

A claimed cycle runs with one turnaround/wait cycle and a single data transfer. The block asserts the device-select output one cycle after the address phase and the target-ready output one cycle later. A burst is disconnected after its first transfer. Other logic in the agent takes the decode enables, the programmed memory window base and the interrupt routing value straight from output ports.

Top module: `cfg_space_target`

## Requirements
- R1: A cycle is claimed only in its address phase (the first clock with `frame_n_i` low after a clock with it high), and only when `idsel_i` is 1, `cbe_n_i` is 4'b1010 (read) or 4'b1011 (write), and `ad_i[1:0]` is 2'b00. Otherwise `devsel_n_o` stays high and a write has no effect.
- R2: For a claimed cycle, `devsel_n_o` goes low in the clock after the address phase and `trdy_n_o` goes low one clock later. On a read, `ad_oe_o` is 1 and `ad_o` carries the register selected by `ad_i[7:2]` while `trdy_n_o` is low.
- R3: DWORD 0 reads `{DEVICE_ID, VENDOR_ID}`, DWORD 2 reads `{CLASS_CODE, REV_ID}` and DWORD 11 reads `{SUBSYS_ID, SUBSYS_VID}`. Writes to these DWORDs are ignored.
- R4: On a write, byte lane k (`ad_i[8k+7:8k]`) is written only if `cbe_n_i[k]` is 0 at the transfer clock.
- R5: DWORD 4 is a 32-bit memory window base of 2^BAR0_SIZE_LOG2 bytes (default 4 KB). Bits below the size read zero, so writing all ones reads back 32'hFFFF_F000. The value appears on `bar0_o`.
- R6: Bits [2:0] of DWORD 1 (I/O enable, memory enable, bus-master enable) are writable and drive `cmd_en_o[2:0]`. Bits [15:3] read zero.
- R7: Byte 0 of DWORD 15 is the writable interrupt line and drives `irq_line_o`. Byte 1 reads IRQ_PIN and is not writable.
- R8: Bit 21 of DWORD 1 (the speed-capability status bit) reads CAP_66MHZ. The other status bits read zero and ignore writes.
- R9: DWORD 3 byte 0 (cache line size) and byte 1 (latency timer) are writable; bytes 2 and 3 read zero.
- R10: DWORDs 16 to 16+USER_DWORDS-1 are read/write storage. All other unimplemented DWORDs (5 to 10, 12 to 14, and user DWORDs past the storage) read zero.
- R11: If `frame_n_i` is still low one clock after the address phase, `stop_n_o` goes low together with `trdy_n_o`. After the single transfer, `trdy_n_o` rises while `stop_n_o` and `devsel_n_o` stay low until `frame_n_i` is high. Only the first data phase is written.
- R12: While `irdy_n_i` is high, `trdy_n_o` stays low and nothing is transferred.
- R13: After reset, `devsel_n_o`, `trdy_n_o` and `stop_n_o` are 1, and `ad_oe_o`, `cmd_en_o`, `bar0_o` and `irq_line_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, all signals sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_n_i | input | 1 | Initiator cycle-framing strobe, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| idsel_i | input | 1 | Configuration chip select, active high |
| cbe_n_i | input | 4 | Command in address phase, byte enables (active low) in data phase |
| ad_i | input | 32 | Address/data bus as received |
| ad_o | output | 32 | Read data driven to the bus |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| devsel_n_o | output | 1 | Cycle claimed, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| stop_n_o | output | 1 | Disconnect request, active low |
| cmd_en_o | output | 3 | I/O, memory and bus-master enables |
| bar0_o | output | 32 | Programmed memory window base |
| irq_line_o | output | 8 | Programmed interrupt line |

## Verification
Directed cycles vary one claim condition at a time: chip select low, a non-configuration command, and a type 1 address. This shows that each condition alone blocks the claim and that the blocked write leaves no trace. Byte-enable patterns of one, two and four lanes on writable, read-only and unimplemented DWORDs show which lanes and which fields take data. Bursts with and without initiator wait states show the disconnect sequence and confirm that only the first data phase lands. A seeded random mix of writes and reads over the whole header and user region is compared against a bench model of the register map.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    localparam int IDX_W = 6;

    localparam logic [IDX_W-1:0] IDX_IDENT = 6'd0;
    localparam logic [IDX_W-1:0] IDX_CTRL  = 6'd1;
    localparam logic [IDX_W-1:0] IDX_CLASS = 6'd2;
    localparam logic [IDX_W-1:0] IDX_MISC  = 6'd3;
    localparam logic [IDX_W-1:0] IDX_BAR0  = 6'd4;
    localparam logic [IDX_W-1:0] IDX_SUBSY = 6'd11;
    localparam logic [IDX_W-1:0] IDX_INTR  = 6'd15;
    localparam int               IDX_USER0 = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_HOLD
    } bus_st_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             wr;
    } cfg_req_t;

    function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                                input logic [31:0] new_v,
                                                input logic [3:0]  be_n);
        logic [31:0] res;
        for (int k = 0; k < 4; k++) begin
            res[8*k +: 8] = be_n[k] ? old_v[8*k +: 8] : new_v[8*k +: 8];
        end
        return res;
    endfunction

    function automatic logic is_cfg_cmd(input logic [3:0] cmd);
        return (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
    endfunction

endpackage

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm
    import cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n_i,
    input  logic             irdy_n_i,
    input  logic             idsel_i,
    input  logic [3:0]       cbe_n_i,
    input  logic [7:0]       ad_lo_i,
    output logic             devsel_n_o,
    output logic             trdy_n_o,
    output logic             stop_n_o,
    output logic             ad_oe_o,
    output logic             load_rd_o,
    output logic             wr_fire_o,
    output logic [IDX_W-1:0] idx_o
);

    bus_st_t  st_q, st_d;
    cfg_req_t req_q;
    logic     frame_prev_q;
    logic     burst_q;
    logic     addr_phase;
    logic     claim;
    logic     fire;

    assign addr_phase = (st_q == ST_IDLE) && !frame_n_i && frame_prev_q;
    assign claim      = addr_phase && idsel_i && is_cfg_cmd(cbe_n_i)
                        && (ad_lo_i[1:0] == 2'b00);
    assign fire       = (st_q == ST_XFER) && !irdy_n_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (claim) st_d = ST_WAIT;
            ST_WAIT: st_d = ST_XFER;
            ST_XFER: if (fire) st_d = burst_q ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (frame_n_i) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            req_q        <= '0;
            frame_prev_q <= 1'b1;
            burst_q      <= 1'b0;
        end else begin
            st_q         <= st_d;
            frame_prev_q <= frame_n_i;
            if (claim) begin
                req_q.idx <= ad_lo_i[7:2];
                req_q.wr  <= (cbe_n_i == CMD_CFG_WR);
            end
            if (st_q == ST_WAIT) begin
                burst_q <= !frame_n_i;
            end
        end
    end

    assign devsel_n_o = (st_q == ST_IDLE);
    assign trdy_n_o   = (st_q != ST_XFER);
    assign stop_n_o   = !(((st_q == ST_XFER) && burst_q) || (st_q == ST_HOLD));
    assign ad_oe_o    = (st_q == ST_XFER) && !req_q.wr;
    assign load_rd_o  = (st_q == ST_WAIT);
    assign wr_fire_o  = fire && req_q.wr;
    assign idx_o      = req_q.idx;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID      = 16'h1AB5,
    parameter logic [15:0] DEVICE_ID      = 16'h0C42,
    parameter logic [7:0]  REV_ID         = 8'h03,
    parameter logic [23:0] CLASS_CODE     = 24'h118000,
    parameter logic [15:0] SUBSYS_VID     = 16'h1AB5,
    parameter logic [15:0] SUBSYS_ID      = 16'h0001,
    parameter logic [7:0]  IRQ_PIN        = 8'h01,
    parameter logic        CAP_66MHZ      = 1'b1,
    parameter int          BAR0_SIZE_LOG2 = 12,
    parameter int          USER_DWORDS    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             wr_en_i,
    input  logic [31:0]      wr_data_i,
    input  logic [3:0]       wr_be_n_i,
    output logic [31:0]      rd_data_o,
    output logic [2:0]       cmd_en_o,
    output logic [31:0]      bar0_o,
    output logic [7:0]       irq_line_o
);

    localparam logic [31:0] BAR_MASK   = ~((32'h1 << BAR0_SIZE_LOG2) - 32'h1);
    localparam logic [15:0] STATUS_VAL = {10'h0, CAP_66MHZ, 5'h0};

    logic [2:0]  cmd_q;
    logic [7:0]  cls_q;
    logic [7:0]  lat_q;
    logic [31:0] bar_q;
    logic [7:0]  irq_q;
    logic [31:0] user_q [USER_DWORDS];
    logic [31:0] merged;
    logic [31:0] user_rd;

    assign merged = merge_bytes(32'h0, wr_data_i, wr_be_n_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            cls_q <= '0;
            lat_q <= '0;
            bar_q <= '0;
            irq_q <= '0;
        end else if (wr_en_i) begin
            case (idx_i)
                IDX_CTRL: if (!wr_be_n_i[0]) cmd_q <= wr_data_i[2:0];
                IDX_MISC: begin
                    if (!wr_be_n_i[0]) cls_q <= wr_data_i[7:0];
                    if (!wr_be_n_i[1]) lat_q <= wr_data_i[15:8];
                end
                IDX_BAR0: bar_q <= merge_bytes(bar_q, wr_data_i, wr_be_n_i) & BAR_MASK;
                IDX_INTR: if (!wr_be_n_i[0]) irq_q <= wr_data_i[7:0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < USER_DWORDS; g++) begin : g_user
        always_ff @(posedge clk) begin
            if (rst) begin
                user_q[g] <= '0;
            end else if (wr_en_i && (idx_i == IDX_W'(IDX_USER0 + g))) begin
                user_q[g] <= merge_bytes(user_q[g], wr_data_i, wr_be_n_i);
            end
        end
    end

    always_comb begin
        user_rd = '0;
        for (int k = 0; k < USER_DWORDS; k++) begin
            if (idx_i == IDX_W'(IDX_USER0 + k)) user_rd = user_q[k];
        end
    end

    always_comb begin
        case (idx_i)
            IDX_IDENT: rd_data_o = {DEVICE_ID, VENDOR_ID};
            IDX_CTRL:  rd_data_o = {STATUS_VAL, 13'h0, cmd_q};
            IDX_CLASS: rd_data_o = {CLASS_CODE, REV_ID};
            IDX_MISC:  rd_data_o = {16'h0, lat_q, cls_q};
            IDX_BAR0:  rd_data_o = bar_q;
            IDX_SUBSY: rd_data_o = {SUBSYS_ID, SUBSYS_VID};
            IDX_INTR:  rd_data_o = {16'h0, IRQ_PIN, irq_q};
            default:   rd_data_o = user_rd;
        endcase
    end

    assign cmd_en_o   = cmd_q;
    assign bar0_o     = bar_q;
    assign irq_line_o = irq_q;

    logic unused_merge;
    assign unused_merge = ^merged;

endmodule

// File: rtl/cfg_space_target.sv
module cfg_space_target
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID      = 16'h1AB5,
    parameter logic [15:0] DEVICE_ID      = 16'h0C42,
    parameter logic [7:0]  REV_ID         = 8'h03,
    parameter logic [23:0] CLASS_CODE     = 24'h118000,
    parameter logic [15:0] SUBSYS_VID     = 16'h1AB5,
    parameter logic [15:0] SUBSYS_ID      = 16'h0001,
    parameter logic [7:0]  IRQ_PIN        = 8'h01,
    parameter logic        CAP_66MHZ      = 1'b1,
    parameter int          BAR0_SIZE_LOG2 = 12,
    parameter int          USER_DWORDS    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_n_i,
    input  logic        irdy_n_i,
    input  logic        idsel_i,
    input  logic [3:0]  cbe_n_i,
    input  logic [31:0] ad_i,
    output logic [31:0] ad_o,
    output logic        ad_oe_o,
    output logic        devsel_n_o,
    output logic        trdy_n_o,
    output logic        stop_n_o,
    output logic [2:0]  cmd_en_o,
    output logic [31:0] bar0_o,
    output logic [7:0]  irq_line_o
);

    logic [IDX_W-1:0] idx;
    logic             load_rd;
    logic             wr_fire;
    logic [31:0]      rd_data;
    logic [31:0]      ad_q;

    cfg_bus_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .frame_n_i  (frame_n_i),
        .irdy_n_i   (irdy_n_i),
        .idsel_i    (idsel_i),
        .cbe_n_i    (cbe_n_i),
        .ad_lo_i    (ad_i[7:0]),
        .devsel_n_o (devsel_n_o),
        .trdy_n_o   (trdy_n_o),
        .stop_n_o   (stop_n_o),
        .ad_oe_o    (ad_oe_o),
        .load_rd_o  (load_rd),
        .wr_fire_o  (wr_fire),
        .idx_o      (idx)
    );

    cfg_regfile #(
        .VENDOR_ID      (VENDOR_ID),
        .DEVICE_ID      (DEVICE_ID),
        .REV_ID         (REV_ID),
        .CLASS_CODE     (CLASS_CODE),
        .SUBSYS_VID     (SUBSYS_VID),
        .SUBSYS_ID      (SUBSYS_ID),
        .IRQ_PIN        (IRQ_PIN),
        .CAP_66MHZ      (CAP_66MHZ),
        .BAR0_SIZE_LOG2 (BAR0_SIZE_LOG2),
        .USER_DWORDS    (USER_DWORDS)
    ) i_regs (
        .clk        (clk),
        .rst        (rst),
        .idx_i      (idx),
        .wr_en_i    (wr_fire),
        .wr_data_i  (ad_i),
        .wr_be_n_i  (cbe_n_i),
        .rd_data_o  (rd_data),
        .cmd_en_o   (cmd_en_o),
        .bar0_o     (bar0_o),
        .irq_line_o (irq_line_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ad_q <= '0;
        end else if (load_rd) begin
            ad_q <= rd_data;
        end
    end

    assign ad_o = ad_q;

endmodule

// File: rtl/cfg_space_checks.sv
module cfg_space_checks (
    input logic       clk,
    input logic       rst,
    input logic       frame_n_i,
    input logic       irdy_n_i,
    input logic       idsel_i,
    input logic       ad_oe_o,
    input logic       devsel_n_o,
    input logic       trdy_n_o,
    input logic       stop_n_o,
    input logic [7:0] irq_line_o
);

    // R1: no chip select at the start of a cycle means no claim
    a_r1_no_claim_without_idsel: assert property (@(posedge clk) disable iff (rst)
        (!frame_n_i && $past(frame_n_i) && devsel_n_o && !idsel_i) |=> devsel_n_o);

    // R2: target ready follows a claim made at least one clock earlier
    a_r2_trdy_after_devsel: assert property (@(posedge clk) disable iff (rst)
        $fell(trdy_n_o) |-> $past(!devsel_n_o));

    // R2: read data is driven only inside a claimed cycle
    a_r2_oe_needs_devsel: assert property (@(posedge clk) disable iff (rst)
        ad_oe_o |-> !devsel_n_o);

    // R11: disconnect only inside a claimed cycle
    a_r11_stop_needs_devsel: assert property (@(posedge clk) disable iff (rst)
        !stop_n_o |-> !devsel_n_o);

    // R11: exactly one data transfer per cycle
    a_r11_single_transfer: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n_o && !irdy_n_i) |=> trdy_n_o);

    // R12: target ready held while the initiator waits
    a_r12_trdy_hold: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n_o && irdy_n_i) |=> !trdy_n_o);

    // R7: interrupt line changes only after a data transfer
    a_r7_irq_on_transfer: assert property (@(posedge clk) disable iff (rst)
        !$stable(irq_line_o) |-> $past(!trdy_n_o && !irdy_n_i));

endmodule

bind cfg_space_target cfg_space_checks i_checks (
    .clk        (clk),
    .rst        (rst),
    .frame_n_i  (frame_n_i),
    .irdy_n_i   (irdy_n_i),
    .idsel_i    (idsel_i),
    .ad_oe_o    (ad_oe_o),
    .devsel_n_o (devsel_n_o),
    .trdy_n_o   (trdy_n_o),
    .stop_n_o   (stop_n_o),
    .irq_line_o (irq_line_o)
);

// File: tb/test_cfg_space_target.sv
module test_cfg_space_target;

    localparam logic [15:0] T_VEN   = 16'h1AB5;
    localparam logic [15:0] T_DEV   = 16'h0C42;
    localparam logic [7:0]  T_REV   = 8'h03;
    localparam logic [23:0] T_CLASS = 24'h118000;
    localparam logic [15:0] T_SSVID = 16'h1AB5;
    localparam logic [15:0] T_SSID  = 16'h0001;
    localparam logic [7:0]  T_PIN   = 8'h01;
    localparam int          T_USER  = 16;
    localparam logic [3:0]  RD = 4'b1010;
    localparam logic [3:0]  WR = 4'b1011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        idsel = 1'b0;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad = '0;
    logic [31:0] ad_o;
    logic        ad_oe;
    logic        devsel_n;
    logic        trdy_n;
    logic        stop_n;
    logic [2:0]  cmd_en;
    logic [31:0] bar0;
    logic [7:0]  irq_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0]  m_cmd;
    logic [7:0]  m_cls, m_lat, m_irq;
    logic [31:0] m_bar;
    logic [31:0] m_user [T_USER];

    always #10 clk = ~clk;

    cfg_space_target i_cfg_space_target (
        .clk(clk), .rst(rst), .frame_n_i(frame_n), .irdy_n_i(irdy_n),
        .idsel_i(idsel), .cbe_n_i(cbe_n), .ad_i(ad), .ad_o(ad_o),
        .ad_oe_o(ad_oe), .devsel_n_o(devsel_n), .trdy_n_o(trdy_n),
        .stop_n_o(stop_n), .cmd_en_o(cmd_en), .bar0_o(bar0),
        .irq_line_o(irq_line)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be_n);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = be_n[k] ? o[8*k +: 8] : n[8*k +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input int idx);
        case (idx)
            0:  return {T_DEV, T_VEN};
            1:  return {16'h0020, 13'h0, m_cmd};
            2:  return {T_CLASS, T_REV};
            3:  return {16'h0, m_lat, m_cls};
            4:  return m_bar;
            11: return {T_SSID, T_SSVID};
            15: return {16'h0, T_PIN, m_irq};
            default: return (idx >= 16 && idx < 16 + T_USER) ? m_user[idx-16] : 32'h0;
        endcase
    endfunction

    task automatic model_write(input int idx, input logic [31:0] d, input logic [3:0] be_n);
        case (idx)
            1:  if (!be_n[0]) m_cmd = d[2:0];
            3:  begin
                    if (!be_n[0]) m_cls = d[7:0];
                    if (!be_n[1]) m_lat = d[15:8];
                end
            4:  m_bar = mrg(m_bar, d, be_n) & 32'hFFFF_F000;
            15: if (!be_n[0]) m_irq = d[7:0];
            default: if (idx >= 16 && idx < 16 + T_USER) m_user[idx-16] = mrg(m_user[idx-16], d, be_n);
        endcase
    endtask

    task automatic run_cycle(input logic [7:0] addr, input logic [3:0] cmd, input logic sel,
                             input logic [31:0] wdata, input logic [3:0] be_n,
                             input logic burst, input int waits, input logic claim_exp,
                             output logic [31:0] rdata);
        logic is_rd;
        is_rd = (cmd == RD);
        rdata = '0;
        @(negedge clk);
        frame_n = 1'b0; ad = {24'h0, addr}; cbe_n = cmd; idsel = sel; irdy_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        idsel = 1'b0; cbe_n = be_n; ad = is_rd ? 32'h0 : wdata;
        frame_n = !burst; irdy_n = (waits > 0);
        if (!claim_exp) begin
            check("R1 devsel stays high", {31'h0, devsel_n}, 32'h1);
            @(posedge clk);
            @(negedge clk);
            check("R1 devsel stays high later", {31'h0, devsel_n}, 32'h1);
            frame_n = 1'b1; irdy_n = 1'b1;
            return;
        end
        check("R2 devsel after address", {30'h0, devsel_n, trdy_n}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        check("R2 trdy next clock", {31'h0, trdy_n}, 32'h0);
        check("R11 stop only on burst", {31'h0, stop_n}, {31'h0, !burst});
        if (is_rd) begin
            check("R2 read enable", {31'h0, ad_oe}, 32'h1);
            rdata = ad_o;
        end
        for (int w = 0; w < waits; w++) begin
            @(posedge clk);
            @(negedge clk);
            check("R12 trdy held during wait", {31'h0, trdy_n}, 32'h0);
        end
        irdy_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        if (burst) begin
            check("R11 disconnect hold", {29'h0, devsel_n, trdy_n, stop_n}, 32'h2);
            ad = ~wdata;
            frame_n = 1'b1;
            @(posedge clk);
            @(negedge clk);
            irdy_n = 1'b1;
        end else begin
            irdy_n = 1'b1;
        end
        check("R11 release after cycle", {28'h0, devsel_n, trdy_n, stop_n, ad_oe}, 32'he);
    endtask

    task automatic cfg_wr(input int idx, input logic [31:0] d, input logic [3:0] be_n);
        logic [31:0] dummy;
        run_cycle(8'(idx << 2), WR, 1'b1, d, be_n, 1'b0, 0, 1'b1, dummy);
        model_write(idx, d, be_n);
    endtask

    task automatic cfg_rd_check(input int idx, input string req);
        logic [31:0] r;
        run_cycle(8'(idx << 2), RD, 1'b1, 32'h0, 4'h0, 1'b0, 0, 1'b1, r);
        check(req, r, exp_read(idx));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        m_cmd = '0; m_cls = '0; m_lat = '0; m_irq = '0; m_bar = '0;
        for (int k = 0; k < T_USER; k++) m_user[k] = '0;
        void'($urandom(32'd2024));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R13 reset state
        check("R13 idle handshakes", {29'h0, devsel_n, trdy_n, stop_n}, 32'h7);
        check("R13 outputs cleared", {ad_oe, cmd_en, irq_line, bar0[19:0]}, 32'h0);
        check("R13 bar cleared", bar0, 32'h0);

        // R3 identity, writes ignored
        cfg_rd_check(0, "R3 ident");
        cfg_wr(0, 32'hDEAD_BEEF, 4'h0);
        cfg_rd_check(0, "R3 ident after write");
        cfg_wr(2, 32'h1234_5678, 4'h0);
        cfg_rd_check(2, "R3 class/rev");
        cfg_rd_check(11, "R3 subsystem");

        // R6 and R8 command/status
        cfg_wr(1, 32'hFFFF_FFFF, 4'h0);
        cfg_rd_check(1, "R6 R8 command and status");
        check("R6 enables out", {29'h0, cmd_en}, 32'h7);
        cfg_wr(1, 32'h0000_0002, 4'hE);
        check("R6 mem enable only", {29'h0, cmd_en}, 32'h2);

        // R5 size probe
        cfg_wr(4, 32'hFFFF_FFFF, 4'h0);
        cfg_rd_check(4, "R5 size probe");
        check("R5 bar out", bar0, 32'hFFFF_F000);
        cfg_wr(4, 32'hE00A_5ABC, 4'h0);
        check("R5 bar program", bar0, 32'hE00A_5000);

        // R4 byte lanes
        cfg_wr(16, 32'h1122_3344, 4'h0);
        cfg_wr(16, 32'hAABB_CCDD, 4'b1010);
        cfg_rd_check(16, "R4 partial lanes");
        cfg_wr(16, 32'h5566_7788, 4'b0111);
        cfg_rd_check(16, "R4 single top lane");

        // R7 interrupt line
        cfg_wr(15, 32'hFFFF_FF0B, 4'h0);
        cfg_rd_check(15, "R7 irq line and pin");
        check("R7 irq out", {24'h0, irq_line}, 32'h0B);

        // R9 misc
        cfg_wr(3, 32'hFFFF_4010, 4'h0);
        cfg_rd_check(3, "R9 cache/latency");

        // R10 unimplemented and user space edge
        cfg_wr(5, 32'hFFFF_FFFF, 4'h0);
        cfg_rd_check(5, "R10 unimplemented bar1");
        cfg_wr(16 + T_USER, 32'hFFFF_FFFF, 4'h0);
        cfg_rd_check(16 + T_USER, "R10 past user storage");
        cfg_wr(16 + T_USER - 1, 32'hCAFE_F00D, 4'h0);
        cfg_rd_check(16 + T_USER - 1, "R10 last user dword");
        cfg_rd_check(63, "R10 top dword");

        // R1 blocked claims: no idsel, wrong command, type 1
        run_cycle(8'(17 << 2), WR, 1'b0, 32'h9999_9999, 4'h0, 1'b0, 0, 1'b0, r);
        run_cycle(8'(17 << 2), 4'b0111, 1'b1, 32'h9999_9999, 4'h0, 1'b0, 0, 1'b0, r);
        run_cycle(8'((17 << 2) | 1), WR, 1'b1, 32'h9999_9999, 4'h0, 1'b0, 0, 1'b0, r);
        cfg_rd_check(17, "R1 blocked writes left no trace");

        // R11 burst write, only first phase lands
        run_cycle(8'(18 << 2), WR, 1'b1, 32'h0BAD_C0DE, 4'h0, 1'b1, 0, 1'b1, r);
        model_write(18, 32'h0BAD_C0DE, 4'h0);
        cfg_rd_check(18, "R11 burst wrote first phase only");

        // R12 wait states, burst read and write
        run_cycle(8'(18 << 2), RD, 1'b1, 32'h0, 4'h0, 1'b1, 3, 1'b1, r);
        check("R12 read after waits", r, exp_read(18));
        run_cycle(8'(19 << 2), WR, 1'b1, 32'h7777_1111, 4'b1100, 1'b1, 2, 1'b1, r);
        model_write(19, 32'h7777_1111, 4'b1100);
        cfg_rd_check(19, "R12 write after waits");

        // random mix
        for (int i = 0; i < 60; i++) begin
            int idx;
            logic [31:0] d;
            logic [3:0] be;
            idx = int'($urandom_range(0, 35));
            d   = $urandom;
            be  = 4'($urandom);
            if ($urandom_range(0, 1) == 0) cfg_wr(idx, d, be);
            cfg_rd_check(idx, "R4 R10 random access");
        end
        check("R6 enables final", {29'h0, cmd_en}, {29'h0, m_cmd});
        check("R5 bar final", bar0, m_bar);
        check("R7 irq final", {24'h0, irq_line}, {24'h0, m_irq});

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule